// File: doc/BRIEF.md
# Three-Format Single-Cycle Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Each instruction is a single 32-bit word. The opcode alone selects one of three layouts: a register layout with three register fields and a function code, an immediate layout with two register fields and a 16-bit constant, and a jump layout with a 26-bit target field. The core has a program counter, a 32-entry register file, an ALU that adds, subtracts and compares signed values, and a branch and jump unit. The ALU result also forms the data address.

The instruction port and the data port are both combinational. The core drives an address and receives the word in the same cycle. A store is a single-cycle write strobe with address and data. Execution starts at byte address 0x0040_0000 and the program counter advances by four bytes per word. Surrounding logic, or the testbench, provides the memories as plain arrays.

Top module: `tfc_core`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, the instruction address is 0x0040_0000 and no store is issued. All registers read as zero after reset.
- R2: Register layout (opcode 0) with function code 32 adds, 34 subtracts (rs minus rt) and 42 writes 1 if rs is signed-less-than rt and 0 otherwise. The result goes to the register named in bits 15:11.
- R3: Opcode 8 adds rs to the sign-extended 16-bit constant in bits 15:0. Opcode 10 writes the signed comparison rs < constant as 1 or 0. Both write the register named in bits 20:16.
- R4: Opcode 15 writes the 16-bit constant into the upper half of the bits 20:16 register and zeros into its lower half.
- R5: Opcode 35 loads and opcode 43 stores one word at byte address rs + sign-extended constant. A store drives the bits 20:16 register as write data and raises the write strobe for exactly that cycle. A store writes no register.
- R6: Opcode 4 (equal) and opcode 5 (not equal) compare rs and rt. When taken, the next address is PC + 4 + (sign-extended constant × 4); otherwise it is PC + 4. A negative offset moves backwards.
- R7: Opcode 2 jumps, and opcode 3 jumps and writes PC + 4 into register 31. The target is {(PC+4)[31:28], bits 25:0, 2'b00}.
- R8: Register layout with function code 8 sets the next address to the rs value and writes no register.
- R9: Register 0 always reads zero, and any instruction that names it as its destination leaves it zero.
- R10: An opcode or function code outside those listed writes no register, issues no store, and only advances the address by 4. Every non-redirecting instruction advances the address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 32 | Byte address of the current instruction (program counter) |
| imemData | input | 32 | Instruction word at imemAddr, same cycle |
| dmemAddr | output | 32 | Byte address for a load or store |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe, one cycle per store |
| dmemRdata | input | 32 | Load data at dmemAddr, same cycle |

## Verification
The assertions assume that the instruction word is defined in every cycle after reset, and that a register-jump target is word aligned. The stimulus program keeps every fetched address inside the modelled instruction array and fills unused words with a code that acts as a no-op. The only register-jump in the program uses a value built to be a multiple of four. The program stores every computed value to data memory, so the bench compares a full per-cycle trace of the instruction address and store port against expected values written out by hand.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int DATA_W   = 32;
  localparam int REG_CNT  = 32;
  localparam int LINK_REG = 31;

  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_JMP   = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_UPPER = 6'd15;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} aluOpT;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dstSelT;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_UPPER, WB_LINK} wbSelT;

  typedef struct packed {
    logic   regWrite;
    dstSelT dstSel;
    wbSelT  wbSel;
    aluOpT  aluOp;
    logic   useImm;
    logic   memWrite;
    logic   brEq;
    logic   brNe;
    logic   jumpAbs;
    logic   jumpReg;
  } ctrlT;
endpackage

// File: rtl/tfc_regfile.sv
module tfc_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    raddrA,
  input  logic [AW-1:0]    raddrB,
  output logic [WIDTH-1:0] rdataA,
  output logic [WIDTH-1:0] rdataB,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);
  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdataA = (raddrA == '0) ? '0 : regs[raddrA];
  assign rdataB = (raddrB == '0) ? '0 : regs[raddrB];
endmodule

// File: rtl/tfc_control.sv
module tfc_control
  import tfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_REG: begin
        ctrl.dstSel = DST_RD;
        case (funct)
          FN_ADD: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_ADD; end
          FN_SUB: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_SUB; end
          FN_SLT: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_SLT; end
          FN_JR:  ctrl.jumpReg = 1'b1;
          default: ;
        endcase
      end
      OP_JMP: ctrl.jumpAbs = 1'b1;
      OP_JAL: begin
        ctrl.jumpAbs  = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.dstSel   = DST_LINK;
        ctrl.wbSel    = WB_LINK;
      end
      OP_BEQ: ctrl.brEq = 1'b1;
      OP_BNE: ctrl.brNe = 1'b1;
      OP_ADDI: begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; end
      OP_SLTI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.aluOp    = ALU_SLT;
      end
      OP_UPPER: begin ctrl.regWrite = 1'b1; ctrl.wbSel = WB_UPPER; end
      OP_LOAD: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.wbSel    = WB_MEM;
      end
      OP_STORE: begin ctrl.memWrite = 1'b1; ctrl.useImm = 1'b1; end
      default: ;
    endcase
  end

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memWrite |-> !ctrl.regWrite); // R5
  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.brEq, ctrl.brNe, ctrl.jumpAbs, ctrl.jumpReg})); // R6
  AST_LINK_TO_RA: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_JAL) |-> (ctrl.regWrite && ctrl.dstSel == DST_LINK)); // R7
endmodule

// File: rtl/tfc_datapath.sv
module tfc_datapath
  import tfc_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [DATA_W-1:0] instr,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] dmemAddr,
  output logic [DATA_W-1:0] dmemWdata,
  output logic              dmemWe,
  input  logic [DATA_W-1:0] dmemRdata
);
  localparam int RAW = $clog2(REG_CNT);

  logic [DATA_W-1:0] pc, pcPlus4, pcNext, immSext, opB, aluRes, wrData;
  logic [DATA_W-1:0] rsData, rtData;
  logic [RAW-1:0]    rsAddr, rtAddr, rdAddr, wrAddr;
  logic [15:0]       imm16;
  logic [25:0]       target;
  logic              isEqual, branchTaken;
  logic [4:0]        unusedShamt;

  assign rsAddr      = instr[25:21];
  assign rtAddr      = instr[20:16];
  assign rdAddr      = instr[15:11];
  assign unusedShamt = instr[10:6];
  assign imm16       = instr[15:0];
  assign target      = instr[25:0];
  assign immSext     = {{(DATA_W-16){imm16[15]}}, imm16};

  tfc_regfile #(.WIDTH(DATA_W), .DEPTH(REG_CNT)) regs_i (
    .clk(clk), .rstN(rstN),
    .raddrA(rsAddr), .raddrB(rtAddr),
    .rdataA(rsData), .rdataB(rtData),
    .we(ctrl.regWrite), .waddr(wrAddr), .wdata(wrData)
  );

  assign opB = ctrl.useImm ? immSext : rtData;
  always_comb begin
    unique case (ctrl.aluOp)
      ALU_SUB: aluRes = rsData - opB;
      ALU_SLT: aluRes = {{(DATA_W-1){1'b0}}, $signed(rsData) < $signed(opB)};
      default: aluRes = rsData + opB;
    endcase
  end

  assign isEqual     = (rsData == rtData);
  assign branchTaken = (ctrl.brEq && isEqual) || (ctrl.brNe && !isEqual);
  assign pcPlus4     = pc + 32'd4;

  always_comb begin
    if (ctrl.jumpReg)      pcNext = rsData;
    else if (ctrl.jumpAbs) pcNext = {pcPlus4[31:28], target, 2'b00};
    else if (branchTaken)  pcNext = pcPlus4 + (immSext << 2);
    else                   pcNext = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= RESET_PC;
    else       pc <= pcNext;
  end

  always_comb begin
    unique case (ctrl.dstSel)
      DST_RD:   wrAddr = rdAddr;
      DST_LINK: wrAddr = RAW'(LINK_REG);
      default:  wrAddr = rtAddr;
    endcase
    unique case (ctrl.wbSel)
      WB_MEM:   wrData = dmemRdata;
      WB_UPPER: wrData = {imm16, 16'h0000};
      WB_LINK:  wrData = pcPlus4;
      default:  wrData = aluRes;
    endcase
  end

  assign pcOut     = pc;
  assign dmemAddr  = aluRes;
  assign dmemWdata = rtData;
  assign dmemWe    = ctrl.memWrite;

  AST_RESET_PC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pc == RESET_PC)); // R1
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rsAddr == '0) |-> (rsData == '0)); // R9
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.jumpReg && !ctrl.jumpAbs && !ctrl.brEq && !ctrl.brNe)
      |=> (pc == $past(pc) + 32'd4)); // R10
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    pc[1:0] == 2'b00); // R8
endmodule

// File: rtl/tfc_core.sv
module tfc_core
  import tfc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWdata,
  output logic        dmemWe,
  input  logic [31:0] dmemRdata
);
  ctrlT ctrl;

  tfc_control ctl_i (
    .clk(clk), .rstN(rstN),
    .opcode(imemData[31:26]), .funct(imemData[5:0]),
    .ctrl(ctrl)
  );

  tfc_datapath #(.RESET_PC(RESET_PC)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .instr(imemData),
    .pcOut(imemAddr), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata),
    .dmemWe(dmemWe), .dmemRdata(dmemRdata)
  );
endmodule

// File: tb/tfc_core_tb.sv
`timescale 1ns/1ps
module tfc_core_tb_top;
  localparam logic [31:0] BASE = 32'h0040_0000;
  localparam int STEPS = 29;
  // entry: {pc word index, store strobe, store byte address, store data}
  localparam logic [48:0] TRACE [STEPS] = '{
    {8'd0, 1'b0, 8'd0, 32'h0}, {8'd1, 1'b0, 8'd0, 32'h0},
    {8'd2, 1'b0, 8'd0, 32'h0}, {8'd3, 1'b0, 8'd0, 32'h0},
    {8'd4, 1'b0, 8'd0, 32'h0}, {8'd5, 1'b0, 8'd0, 32'h0},
    {8'd6, 1'b0, 8'd0, 32'h0},
    {8'd7, 1'b1, 8'd0, 32'h0000_0002},
    {8'd8, 1'b1, 8'd4, 32'hFFFF_FFF8},
    {8'd9, 1'b1, 8'd8, 32'h0000_0001},
    {8'd10, 1'b1, 8'd12, 32'h0000_0000},
    {8'd11, 1'b1, 8'd16, 32'h1234_0000},
    {8'd12, 1'b0, 8'd0, 32'h0},
    {8'd13, 1'b1, 8'd20, 32'h0000_0000},
    {8'd14, 1'b0, 8'd0, 32'h0},
    {8'd15, 1'b1, 8'd24, 32'hFFFF_FFF8},
    {8'd16, 1'b0, 8'd0, 32'h0}, {8'd17, 1'b0, 8'd0, 32'h0},
    {8'd20, 1'b0, 8'd0, 32'h0},
    {8'd24, 1'b1, 8'd32, 32'h0040_0054},
    {8'd25, 1'b0, 8'd0, 32'h0}, {8'd26, 1'b0, 8'd0, 32'h0},
    {8'd27, 1'b0, 8'd0, 32'h0}, {8'd29, 1'b0, 8'd0, 32'h0},
    {8'd30, 1'b0, 8'd0, 32'h0}, {8'd31, 1'b0, 8'd0, 32'h0},
    {8'd33, 1'b1, 8'd36, 32'h0000_0000},
    {8'd34, 1'b0, 8'd0, 32'h0}, {8'd34, 1'b0, 8'd0, 32'h0}
  };
  // requirement tag for each trace step
  localparam string TAGS [STEPS] = '{
    "R1", "R4", "R3", "R3", "R2", "R2", "R3", "R2", "R2", "R2", "R3", "R4",
    "R9", "R9", "R5", "R5", "R6", "R6", "R6", "R7", "R7", "R4", "R3", "R8",
    "R10", "R10", "R7", "R6", "R6"
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic dmemWe;
  logic [31:0] imem [64];
  logic [31:0] dmem [16];
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tfc_core dut_i (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRdata(dmemRdata)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[5:2]];
  always @(posedge clk) if (dmemWe) dmem[dmemAddr[5:2]] <= dmemWdata;

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt,
                                       logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs,
                                       logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encJ(logic [5:0] op, logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
    imem[0]  = encI(15, 0, 1, 16'h1234);   // upper constant
    imem[1]  = encI(8, 0, 2, 16'd5);
    imem[2]  = encI(8, 0, 3, 16'hFFFD);     // -3
    imem[3]  = encR(2, 3, 4, 32);           // 2
    imem[4]  = encR(3, 2, 5, 34);           // -8
    imem[5]  = encR(3, 2, 6, 42);           // 1
    imem[6]  = encI(10, 2, 7, 16'hFFFF);    // 5 < -1 -> 0
    imem[7]  = encI(43, 0, 4, 16'd0);
    imem[8]  = encI(43, 0, 5, 16'd4);
    imem[9]  = encI(43, 0, 6, 16'd8);
    imem[10] = encI(43, 0, 7, 16'd12);
    imem[11] = encI(43, 0, 1, 16'd16);
    imem[12] = encI(8, 0, 0, 16'd7);        // write to register 0
    imem[13] = encI(43, 0, 0, 16'd20);
    imem[14] = encI(35, 0, 8, 16'd4);
    imem[15] = encI(43, 0, 8, 16'd24);
    imem[16] = encI(4, 2, 3, 16'd5);        // not taken
    imem[17] = encI(5, 2, 3, 16'd2);        // taken to 20
    imem[18] = encI(43, 0, 2, 16'd28);
    imem[19] = encI(43, 0, 2, 16'd28);
    imem[20] = encJ(3, 26'h010_0018);       // link, to 24
    for (int i = 21; i < 24; i++) imem[i] = encI(43, 0, 2, 16'd28);
    imem[24] = encI(43, 0, 31, 16'd32);
    imem[25] = encI(15, 0, 9, 16'h0040);
    imem[26] = encI(8, 9, 9, 16'h0074);
    imem[27] = encR(9, 0, 0, 8);            // register jump to 29
    imem[28] = encI(43, 0, 2, 16'd28);
    imem[29] = {6'd63, 5'd2, 5'd11, 16'h0001}; // undefined opcode
    imem[30] = encR(2, 2, 10, 63);          // undefined function code
    imem[31] = encJ(2, 26'h010_0021);       // plain jump to 33
    imem[32] = encI(43, 0, 2, 16'd40);
    imem[33] = encI(43, 0, 10, 16'd36);
    imem[34] = encI(4, 0, 0, 16'hFFFF);     // branch to self

    repeat (3) @(negedge clk);
    chk("R1 reset pc", imemAddr, BASE);
    chk("R1 reset no store", {31'b0, dmemWe}, 32'h0);
    rstN = 1'b1;
    #1;
    for (int k = 0; k < STEPS; k++) begin
      logic [48:0] e;
      e = TRACE[k];
      chk({TAGS[k], " pc"}, imemAddr, BASE + {22'b0, e[48:41], 2'b00});
      chk({TAGS[k], " store strobe"}, {31'b0, dmemWe}, {31'b0, e[40]});
      if (e[40]) begin
        chk({TAGS[k], " store addr"}, dmemAddr, {24'b0, e[39:32]});
        chk({TAGS[k], " store data"}, dmemWdata, e[31:0]);
      end
      @(posedge clk);
      @(negedge clk);
      #1;
    end
    // skipped stores must not have reached memory
    chk("R6 skipped store", dmem[7], 32'h0);
    chk("R7 skipped store", dmem[10], 32'h0);
    chk("R5 loaded value stored", dmem[6], 32'hFFFF_FFF8);
    // reset in mid-run
    rstN = 1'b0;
    #1;
    chk("R1 reset mid-run pc", imemAddr, BASE);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 restart pc", imemAddr, BASE);
    @(posedge clk);
    @(negedge clk);
    chk("R10 step after restart", imemAddr, BASE + 32'd4);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule